// File: doc/BRIEF.md
# Pipelined Bus Cycle Issue Controller

This block is the master-side logic of a processor bus that decides, clock by clock, whether the pending request may open a new bus cycle by raising the address strobe. Up to three cycles can be open at once. A cycle is opened by the strobe and closed by its last ready beat. A new cycle that overlaps open ones is allowed only after the system has signalled next-address for the youngest open cycle, and only when the request's type is compatible with the cycles already open.

The controller also tells the data path in which clock the cache-enable and write-policy inputs of each cycle are to be captured. That is the next-address clock when next-address arrives before the first ready of that cycle. Otherwise it is the clock of the first ready. Data movement, bus hand-off to another master and restart after back-off are handled elsewhere.

Top module: `pipe_issue_ctrl`

## Requirements
- R1: After reset the open-cycle count is 0 and no strobe, attribute-capture pulse or retirement is produced until a request arrives.
- R2: The open-cycle count `busy_count` never exceeds 3, and no strobe is issued while 3 cycles are open.
- R3: With no cycle open, a valid request is strobed at once if no other rule blocks it. With cycles open, it is strobed only if `next_addr` was seen active, without back-off, in an earlier clock while the youngest open cycle was youngest.
- R4: No strobe is issued in a clock where `hold_req`, `backoff` or `addr_hold` is high.
- R5: Two strobes are never issued in consecutive clocks.
- R6: Request kinds 3 (port I/O), 4 (special) and 5 (interrupt acknowledge) are strobed only when no cycle is open.
- R7: While `bus_lock` is high and a cycle is open, data kinds 0 (single data) and 1 (line fill) are not strobed. Kind 2 (instruction fetch) is not affected.
- R8: A line fill (kind 1) is strobed while another line fill is open only when `req_alias` is high.
- R9: In the clock right after a cycle retires, a request whose `req_write` differs from the direction of the retired cycle is not strobed. This leaves one idle clock for bus turnaround.
- R10: `attr_on_na` pulses in the clock where `next_addr` is seen for the youngest open cycle, but only if that cycle's first ready has not yet come and the ready is not in the same clock.
- R11: `attr_on_ready` pulses with the first ready of the oldest open cycle when its attributes were not captured earlier. Each cycle gets exactly one capture.
- R12: A cycle holds `req_beats`+1 beats and retires on its last ready. Ready and next-address are ignored in clocks where `backoff` is high. Readies are matched to cycles oldest first, and ready with no open cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is pending |
| req_kind | input | 3 | Request kind: 0 data, 1 line fill, 2 fetch, 3 port I/O, 4 special, 5 interrupt acknowledge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_beats | input | 2 | Number of beats minus one |
| req_alias | input | 1 | Line fill may overlap another line fill |
| bus_lock | input | 1 | Bus lock is active |
| next_addr | input | 1 | System accepts a further address |
| bus_ready | input | 1 | Data beat completes |
| hold_req | input | 1 | Another master asks for the bus |
| backoff | input | 1 | Abort and release the bus |
| addr_hold | input | 1 | Address bus held for an inquiry |
| addr_strobe | output | 1 | New cycle starts this clock; the request is consumed |
| busy_count | output | 2 | Number of open cycles |
| attr_on_na | output | 1 | Capture cache attributes of the youngest cycle now (next-address clock) |
| attr_on_ready | output | 1 | Capture cache attributes of the oldest cycle now (first ready) |

## Verification
The hardest state to reach is three open cycles of mixed kinds, where each later strobe had to wait for a next-address on the then-youngest cycle. At the same time a line fill or locked data request has to be waiting against them. Random stimulus reaches it by alternating long stretches of scarce ready with stretches of plentiful ready, while next-address stays frequent, so the count climbs to three and drains again many times. A cycle-level model in the bench tags every strobe mismatch with the rule that should have decided it.

// File: rtl/pipe_issue_pkg.sv
package pipe_issue_pkg;

    typedef enum logic [2:0] {
        K_DATA    = 3'd0,
        K_FILL    = 3'd1,
        K_FETCH   = 3'd2,
        K_IO      = 3'd3,
        K_SPECIAL = 3'd4,
        K_INTACK  = 3'd5
    } kind_e;

    // kinds that must find the bus empty
    function automatic logic kind_solo(input kind_e k);
        return (k == K_IO) || (k == K_SPECIAL) || (k == K_INTACK);
    endfunction

    // kinds held off by an active lock when pipelined
    function automatic logic kind_data(input kind_e k);
        return (k == K_DATA) || (k == K_FILL);
    endfunction

endpackage

// File: rtl/cycle_tracker.sv
module cycle_tracker
    import pipe_issue_pkg::*;
#(
    parameter int DEPTH  = 3,
    parameter int BEAT_W = 2,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  kind_e             push_kind,
    input  logic              push_write,
    input  logic [BEAT_W-1:0] push_beats,
    input  logic              ready_in,
    input  logic              na_in,
    output logic [CNT_W-1:0]  count,
    output logic              fill_open,
    output logic              tail_na,
    output logic              retire,
    output logic              retire_write,
    output logic              attr_na,
    output logic              attr_rdy
);

    typedef struct packed {
        logic            ok;
        kind_e           kind;
        logic            wr;
        logic [BEAT_W:0] left;
        logic            na;
        logic            attr;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] s;
        logic  [CNT_W-1:0] cnt;
    } trk_t;

    trk_t trk_q, trk_d;
    logic [CNT_W-1:0] tail_idx;
    logic [CNT_W-1:0] cnt_mid;

    assign tail_idx = trk_q.cnt - CNT_W'(1);

    always_comb begin
        trk_d        = trk_q;
        retire       = 1'b0;
        retire_write = trk_q.s[0].wr;
        attr_na      = 1'b0;
        attr_rdy     = 1'b0;
        fill_open    = 1'b0;
        tail_na      = 1'b0;

        for (int i = 0; i < DEPTH; i++) begin
            if (trk_q.s[i].ok && trk_q.s[i].kind == K_FILL) fill_open = 1'b1;
            if (trk_q.cnt != '0 && CNT_W'(i) == tail_idx) tail_na = trk_q.s[i].na;
        end

        // ready goes to the oldest open cycle
        if (ready_in && trk_q.cnt != '0) begin
            if (!trk_q.s[0].attr) begin
                attr_rdy          = 1'b1;
                trk_d.s[0].attr   = 1'b1;
            end
            if (trk_q.s[0].left == (BEAT_W+1)'(1)) retire = 1'b1;
            else trk_d.s[0].left = trk_q.s[0].left - (BEAT_W+1)'(1);
        end

        // next-address goes to the youngest open cycle
        if (na_in && trk_q.cnt != '0) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == tail_idx) begin
                    trk_d.s[i].na = 1'b1;
                    if (!trk_q.s[i].attr && !(ready_in && i == 0)) begin
                        attr_na         = 1'b1;
                        trk_d.s[i].attr = 1'b1;
                    end
                end
            end
        end

        if (retire) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i + 1 < DEPTH) trk_d.s[i] = trk_d.s[(i+1) % DEPTH];
                else               trk_d.s[i] = '0;
            end
        end
        cnt_mid = trk_q.cnt - CNT_W'(retire);

        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == cnt_mid) begin
                    trk_d.s[i].ok   = 1'b1;
                    trk_d.s[i].kind = push_kind;
                    trk_d.s[i].wr   = push_write;
                    trk_d.s[i].left = {1'b0, push_beats} + (BEAT_W+1)'(1);
                    trk_d.s[i].na   = 1'b0;
                    trk_d.s[i].attr = 1'b0;
                end
            end
        end
        trk_d.cnt = cnt_mid + CNT_W'(push);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign count = trk_q.cnt;

    // R12: nothing retires or captures while the tracker is empty
    p_empty_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (!retire && !attr_rdy && !attr_na));

    // R11: a single open cycle never captures twice in one clock
    p_one_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(1)) |-> !(attr_na && attr_rdy));

endmodule

// File: rtl/issue_gate.sv
module issue_gate
    import pipe_issue_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int CNT_W = 2
) (
    input  logic             req_valid,
    input  kind_e            req_kind,
    input  logic             req_write,
    input  logic             req_alias,
    input  logic             bus_lock,
    input  logic             stall,
    input  logic             strobe_last,
    input  logic             turn_ok,
    input  logic             turn_wr,
    input  logic [CNT_W-1:0] count,
    input  logic             fill_open,
    input  logic             tail_na,
    output logic             go
);

    logic open_any, room, turn_block, compat;

    always_comb begin
        open_any   = (count != '0);
        room       = (count < CNT_W'(DEPTH));
        turn_block = turn_ok && (turn_wr != req_write);
        compat     = 1'b1;
        if (open_any) begin
            if (kind_solo(req_kind))                          compat = 1'b0;
            if (bus_lock && kind_data(req_kind))              compat = 1'b0;
            if (req_kind == K_FILL && fill_open && !req_alias) compat = 1'b0;
            if (!tail_na)                                     compat = 1'b0;
        end
        go = req_valid && !stall && !strobe_last && !turn_block && room && compat;
    end

endmodule

// File: rtl/pipe_issue_ctrl.sv
module pipe_issue_ctrl
    import pipe_issue_pkg::*;
#(
    parameter  int DEPTH  = 3,
    parameter  int BEAT_W = 2,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic              req_write,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic              req_alias,
    input  logic              bus_lock,
    input  logic              next_addr,
    input  logic              bus_ready,
    input  logic              hold_req,
    input  logic              backoff,
    input  logic              addr_hold,
    output logic              addr_strobe,
    output logic [CNT_W-1:0]  busy_count,
    output logic              attr_on_na,
    output logic              attr_on_ready
);

    typedef struct packed {
        logic strobe;
        logic turn_ok;
        logic turn_wr;
    } ctl_t;

    ctl_t  ctl_q, ctl_d;
    kind_e kind;
    logic  go, fill_open, tail_na, retire, retire_write;

    assign kind = kind_e'(req_kind);

    issue_gate #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_gate (
        .req_valid   (req_valid),
        .req_kind    (kind),
        .req_write   (req_write),
        .req_alias   (req_alias),
        .bus_lock    (bus_lock),
        .stall       (hold_req || backoff || addr_hold),
        .strobe_last (ctl_q.strobe),
        .turn_ok     (ctl_q.turn_ok),
        .turn_wr     (ctl_q.turn_wr),
        .count       (busy_count),
        .fill_open   (fill_open),
        .tail_na     (tail_na),
        .go          (go)
    );

    cycle_tracker #(.DEPTH(DEPTH), .BEAT_W(BEAT_W), .CNT_W(CNT_W)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (go),
        .push_kind    (kind),
        .push_write   (req_write),
        .push_beats   (req_beats),
        .ready_in     (bus_ready && !backoff),
        .na_in        (next_addr && !backoff),
        .count        (busy_count),
        .fill_open    (fill_open),
        .tail_na      (tail_na),
        .retire       (retire),
        .retire_write (retire_write),
        .attr_na      (attr_on_na),
        .attr_rdy     (attr_on_ready)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.strobe  = go;
        ctl_d.turn_ok = retire;
        ctl_d.turn_wr = retire_write;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign addr_strobe = go;

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_count <= CNT_W'(DEPTH)));

    p_stall_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req || backoff || addr_hold) |-> !addr_strobe);

    p_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> !addr_strobe);

    p_solo_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && kind_solo(kind)) |-> (busy_count == '0));

    p_grow_needs_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_count > $past(busy_count)) |-> $past(addr_strobe));

endmodule

// File: tb/test_pipe_issue_ctrl.sv
module test_pipe_issue_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 0, req_write = 0, req_alias = 0, bus_lock = 0;
    logic [2:0] req_kind = 0;
    logic [1:0] req_beats = 0;
    logic       next_addr = 0, bus_ready = 0, hold_req = 0, backoff = 0, addr_hold = 0;
    logic       addr_strobe, attr_on_na, attr_on_ready;
    logic [1:0] busy_count;

    int checks = 0, errors = 0;

    // bench model of the open cycles, oldest at index 0
    int m_kind[3], m_wr[3], m_left[3], m_na[3], m_attr[3];
    int m_cnt = 0, m_stb = 0, m_tv = 0, m_td = 0;

    always #5 clk = ~clk;

    pipe_issue_ctrl i_pipe_issue_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_write(req_write), .req_beats(req_beats), .req_alias(req_alias),
        .bus_lock(bus_lock), .next_addr(next_addr), .bus_ready(bus_ready),
        .hold_req(hold_req), .backoff(backoff), .addr_hold(addr_hold),
        .addr_strobe(addr_strobe), .busy_count(busy_count),
        .attr_on_na(attr_on_na), .attr_on_ready(attr_on_ready)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // returns 1 when the request may start; why names the deciding rule
    function automatic int model_go(output string why);
        int fills = 0;
        for (int i = 0; i < m_cnt; i++) if (m_kind[i] == 1) fills++;
        why = "R3";
        if (!req_valid) return 0;
        if (hold_req || backoff || addr_hold) begin why = "R4"; return 0; end
        if (m_stb != 0) begin why = "R5"; return 0; end
        if (m_tv != 0 && m_td != int'(req_write)) begin why = "R9"; return 0; end
        if (m_cnt >= 3) begin why = "R2"; return 0; end
        if (m_cnt > 0) begin
            if (req_kind >= 3) begin why = "R6"; return 0; end
            if (bus_lock && req_kind <= 1) begin why = "R7"; return 0; end
            if (req_kind == 1 && fills > 0 && !req_alias) begin why = "R8"; return 0; end
            if (m_na[m_cnt-1] == 0) begin why = "R3"; return 0; end
        end
        return 1;
    endfunction

    int e_go, e_an, e_ar, e_ret;

    task automatic eval_and_check();
        string why;
        int rdy, na;
        e_go = model_go(why);
        rdy = (bus_ready && !backoff) ? 1 : 0;
        na  = (next_addr && !backoff) ? 1 : 0;
        e_ar = 0; e_an = 0; e_ret = 0;
        if (rdy && m_cnt > 0) begin
            if (!m_attr[0]) e_ar = 1;
            if (m_left[0] == 1) e_ret = 1;
        end
        if (na && m_cnt > 0 && !m_attr[m_cnt-1] && !(rdy && m_cnt == 1)) e_an = 1;
        check(addr_strobe, e_go, why);
        check(busy_count, m_cnt, "R12");
        check(attr_on_na, e_an, "R10");
        check(attr_on_ready, e_ar, "R11");
    endtask

    task automatic model_step();
        int rdy, na, t;
        rdy = (bus_ready && !backoff) ? 1 : 0;
        na  = (next_addr && !backoff) ? 1 : 0;
        t = m_cnt - 1;
        if (rdy && m_cnt > 0) begin
            if (e_ar) m_attr[0] = 1;
            m_left[0]--;
        end
        if (na && m_cnt > 0) begin
            m_na[t] = 1;
            if (e_an) m_attr[t] = 1;
        end
        m_tv = e_ret;
        if (e_ret) begin
            m_td = m_wr[0];
            for (int i = 0; i < 2; i++) begin
                m_kind[i] = m_kind[i+1]; m_wr[i] = m_wr[i+1]; m_left[i] = m_left[i+1];
                m_na[i] = m_na[i+1]; m_attr[i] = m_attr[i+1];
            end
            m_cnt--;
        end
        if (e_go) begin
            m_kind[m_cnt] = req_kind; m_wr[m_cnt] = req_write;
            m_left[m_cnt] = req_beats + 1; m_na[m_cnt] = 0; m_attr[m_cnt] = 0;
            m_cnt++;
        end
        m_stb = e_go;
    endtask

    // one clock: inputs set at negedge, outputs checked, model advanced at posedge
    task automatic cycle();
        #1 eval_and_check();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic drive_quiet();
        req_valid = 0; next_addr = 0; bus_ready = 0; hold_req = 0;
        backoff = 0; addr_hold = 0; bus_lock = 0; req_alias = 0;
    endtask

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy_count, 0, "R1");
        check(addr_strobe, 0, "R1");
        rst_n = 1'b1;
        drive_quiet();
        @(negedge clk);
        cycle();
        check(busy_count, 0, "R1");

        // directed: fill, next-address before first ready -> capture at NA (R10)
        req_valid = 1; req_kind = 1; req_write = 0; req_beats = 3;
        cycle();                        // strobe
        req_valid = 0; next_addr = 1;
        #1 check(attr_on_na, 1, "R10 early next-address");
        cycle();
        // second fill without alias must wait (R8), with alias may go
        next_addr = 0; req_valid = 1; req_kind = 1; req_alias = 0;
        #1 check(addr_strobe, 0, "R8 fill into fill");
        cycle();
        req_alias = 1;
        #1 check(addr_strobe, 1, "R8 aliased fill");
        cycle();
        drive_quiet();
        // first ready on oldest: attribute already taken, no capture (R11)
        bus_ready = 1;
        #1 check(attr_on_ready, 0, "R11 already captured");
        cycle();
        // drain with backoff active: ignored (R12)
        backoff = 1;
        repeat (2) cycle();
        backoff = 0;
        repeat (12) cycle();
        check(busy_count, 0, "R12 drained");
        drive_quiet();

        // random phases
        for (int ph = 0; ph < 16; ph++) begin
            int rp;
            rp = (ph % 2 == 0) ? 12 : 60;
            for (int n = 0; n < 250; n++) begin
                req_valid = ($urandom % 100) < 75;
                req_kind  = 3'($urandom % 6);
                req_write = ($urandom % 3) == 0;
                req_beats = 2'($urandom % 4);
                req_alias = $urandom % 2;
                bus_lock  = ($urandom % 100) < 20;
                next_addr = ($urandom % 100) < 45;
                bus_ready = ($urandom % 100) < rp;
                hold_req  = ($urandom % 100) < 5;
                backoff   = ($urandom % 100) < 4;
                addr_hold = ($urandom % 100) < 4;
                cycle();
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule